// File: doc/BRIEF.md
# GPIO Edge Detect Interrupt Unit

This unit watches 128 general-purpose input pins, organised as four banks of 32, for rising and falling transitions. Software enables edge detection per pin and per polarity. Every detected edge sets a sticky bit in that bank's status register, and software clears the bit by writing a one to it. The unit compares each pin with its own copy from the previous clock, so the pins must arrive already synchronised and filtered.

The status bits drive three registered, level-sensitive interrupt lines. Pins 0 and 1 each have a line of their own. All other pins share the third line. While the processor is halted, a level change on an input pin that a fixed per-bank wake mask selects produces a one-cycle wake-up pulse. This pulse does not depend on the edge enables. Pin direction comes from a neighbouring register block. Only pins configured as inputs can record edges or raise a wake-up request.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: The rising-enable registers are at byte offsets 0x030, 0x034, 0x038 and 0x130 for banks 0 to 3. The falling-enable registers are at 0x03C, 0x040, 0x044 and 0x13C. Both are read/write, and reset sets every enable and status register to zero.
- R2: A low-to-high change on pin n (bank n/32, bit n%32) sets status bit n on the next clock edge, but only when its rising enable is 1 and pinDir bit n is 0 (input).
- R3: A high-to-low change on pin n sets status bit n, but only when its falling enable is 1 and the pin is an input. A transition of a polarity that is not enabled leaves the status unchanged.
- R4: A pin whose pinDir bit is 1 (output) never sets a status bit, whatever its enables.
- R5: The status registers are at 0x048, 0x04C, 0x050 and 0x148. A read returns the sticky bits. A write clears each bit written as 1 and leaves the bits written as 0.
- R6: When an edge is detected on a status bit in the same cycle as a write that clears that bit, the bit stays set.
- R7: irqPin0 and irqPin1 equal bank 0 status bits 0 and 1, one clock after the status register.
- R8: irqShared, one clock after the status register, is the OR of bank 0 status bits 31:2 and all status bits of banks 1 to 3.
- R9: While halted is 1, any level change on an input pin in the wake mask gives a one-cycle wakeReq pulse on the next clock, regardless of the enables. The mask is 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0 to 3.
- R10: No wake pulse comes from a pin outside the mask, from an output pin, or while halted is 0.
- R11: Reads of any other offset return 0, and writes to any other offset change no register.
- R12: In the first clock after reset, pin levels that differ from zero produce neither a status bit nor a wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 128 | Synchronised pin levels, pin n at bit n |
| pinDir | input | 128 | Direction per pin, 1 = output, 0 = input |
| halted | input | 1 | Processor halted flag |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| irqPin0 | output | 1 | Interrupt for pin 0 |
| irqPin1 | output | 1 | Interrupt for pin 1 |
| irqShared | output | 1 | Interrupt for all other pins |
| wakeReq | output | 1 | One-cycle wake-up pulse |

## Verification
The hardest case to reach from the ports is a new edge landing on a status bit in the very cycle that a software clear targets it. The bench first sets a bit through a rising edge. It then drives the opposite transition on the pin and a write-one-to-clear of that bit at the same falling clock edge, so that both reach the same rising edge. The first cycle after reset is also hard to reach, because pins must already be high with the processor halted. The bench holds all pins high and halted asserted through reset to show that no pulse or status results.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int GE_BANKS  = 4;
  localparam int GE_ADDR_W = 12;

  localparam logic [GE_ADDR_W-1:0] RISE_BASE = 12'h030;
  localparam logic [GE_ADDR_W-1:0] FALL_BASE = 12'h03C;
  localparam logic [GE_ADDR_W-1:0] STAT_BASE = 12'h048;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_RISE = 2'd1,
    RD_FALL = 2'd2,
    RD_STAT = 2'd3
  } rdKind_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic [GE_BANKS-1:0] riseWr;
    logic [GE_BANKS-1:0] fallWr;
    logic [GE_BANKS-1:0] statClr;
    rdKind_e             rdKind;
    logic [GE_BANKS-1:0] rdBank;
  } regStrobe_t;

  // Banks 0..2 are packed at 4-byte steps; later banks sit 0x100 higher
  function automatic logic [GE_ADDR_W-1:0] bankOffset(
      input logic [GE_ADDR_W-1:0] base, input int bank);
    int off;
    if (bank < 3) off = int'(base) + 4 * bank;
    else          off = int'(base) + 'h100 + 4 * (bank - 3);
    return GE_ADDR_W'(off);
  endfunction

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic [GE_ADDR_W-1:0] regAddr,
  input  logic                 regWrEn,
  output regStrobe_t           strobe
);

  logic [GE_BANKS-1:0] hitRise, hitFall, hitStat;

  for (genvar b = 0; b < GE_BANKS; b++) begin : g_dec
    assign hitRise[b] = (regAddr == bankOffset(RISE_BASE, b));
    assign hitFall[b] = (regAddr == bankOffset(FALL_BASE, b));
    assign hitStat[b] = (regAddr == bankOffset(STAT_BASE, b));
  end

  always_comb begin
    strobe         = '0;
    strobe.riseWr  = hitRise & {GE_BANKS{regWrEn}};
    strobe.fallWr  = hitFall & {GE_BANKS{regWrEn}};
    strobe.statClr = hitStat & {GE_BANKS{regWrEn}};
    strobe.rdBank  = hitRise | hitFall | hitStat;
    if (|hitRise)      strobe.rdKind = RD_RISE;
    else if (|hitFall) strobe.rdKind = RD_FALL;
    else if (|hitStat) strobe.rdKind = RD_STAT;
    else               strobe.rdKind = RD_NONE;
  end

endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int BANK_W = 32,
  localparam int TOT   = GE_BANKS * BANK_W,
  parameter logic [TOT-1:0] WAKE_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TOT-1:0]    pinIn,
  input  logic [TOT-1:0]    pinDir,
  input  logic              halted,
  input  logic [BANK_W-1:0] wrData,
  input  regStrobe_t        strobe,
  output logic [BANK_W-1:0] rdData,
  output logic              irqPin0,
  output logic              irqPin1,
  output logic              irqShared,
  output logic              wakeReq,
  output logic [TOT-1:0]    statusFlat,
  output logic [TOT-1:0]    clrFlat
);

  logic [TOT-1:0] riseEn, fallEn, prevLevel, changed, edgeHit;
  logic           primed;

  assign changed = (pinIn ^ prevLevel) & ~pinDir & {TOT{primed}};
  assign edgeHit = changed & ((pinIn & riseEn) | (~pinIn & fallEn));

  for (genvar b = 0; b < GE_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;

    assign clrFlat[LO +: BANK_W] = strobe.statClr[b] ? wrData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        riseEn[LO +: BANK_W]     <= '0;
        fallEn[LO +: BANK_W]     <= '0;
        statusFlat[LO +: BANK_W] <= '0;
      end else begin
        if (strobe.riseWr[b]) riseEn[LO +: BANK_W] <= wrData;
        if (strobe.fallWr[b]) fallEn[LO +: BANK_W] <= wrData;
        statusFlat[LO +: BANK_W] <= (statusFlat[LO +: BANK_W] & ~clrFlat[LO +: BANK_W])
                                  | edgeHit[LO +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= '0;
      primed    <= 1'b0;
      wakeReq   <= 1'b0;
      irqPin0   <= 1'b0;
      irqPin1   <= 1'b0;
      irqShared <= 1'b0;
    end else begin
      prevLevel <= pinIn;
      primed    <= 1'b1;
      wakeReq   <= halted & |(changed & WAKE_MASK);
      irqPin0   <= statusFlat[0];
      irqPin1   <= statusFlat[1];
      irqShared <= |statusFlat[TOT-1:2];
    end
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < GE_BANKS; b++) begin
      if (strobe.rdBank[b]) begin
        case (strobe.rdKind)
          RD_RISE: rdData = riseEn[b*BANK_W +: BANK_W];
          RD_FALL: rdData = fallEn[b*BANK_W +: BANK_W];
          RD_STAT: rdData = statusFlat[b*BANK_W +: BANK_W];
          default: rdData = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_edge_irq_unit.sv
module gpio_edge_irq_unit
  import gpio_edge_pkg::*;
#(
  parameter int BANK_W = 32,
  localparam int TOT   = GE_BANKS * BANK_W,
  parameter logic [TOT-1:0] WAKE_MASK =
    {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TOT-1:0]       pinIn,
  input  logic [TOT-1:0]       pinDir,
  input  logic                 halted,
  input  logic [GE_ADDR_W-1:0] regAddr,
  input  logic                 regWrEn,
  input  logic [BANK_W-1:0]    regWrData,
  output logic [BANK_W-1:0]    regRdData,
  output logic                 irqPin0,
  output logic                 irqPin1,
  output logic                 irqShared,
  output logic                 wakeReq
);

  regStrobe_t     strobe;
  logic [TOT-1:0] statusFlat, clrFlat;

  gpio_edge_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  gpio_edge_dp #(.BANK_W(BANK_W), .WAKE_MASK(WAKE_MASK)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .pinDir     (pinDir),
    .halted     (halted),
    .wrData     (regWrData),
    .strobe     (strobe),
    .rdData     (regRdData),
    .irqPin0    (irqPin0),
    .irqPin1    (irqPin1),
    .irqShared  (irqShared),
    .wakeReq    (wakeReq),
    .statusFlat (statusFlat),
    .clrFlat    (clrFlat)
  );

endmodule

// File: rtl/gpio_edge_checker.sv
module gpio_edge_checker #(
  parameter int TOT = 128
) (
  input logic           clk,
  input logic           rstN,
  input logic [TOT-1:0] pinDir,
  input logic           halted,
  input logic [TOT-1:0] statusFlat,
  input logic [TOT-1:0] clrFlat,
  input logic           irqPin0,
  input logic           irqPin1,
  input logic           irqShared,
  input logic           wakeReq
);

  // R4: newly set status bits belong to input pins only
  a_r4_output_never_latches: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusFlat & ~$past(statusFlat) & $past(pinDir)) == '0));

  // R5: a set bit leaves only through a clearing write
  a_r5_sticky_until_clear: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusFlat) & ~$past(clrFlat) & ~statusFlat) == '0));

  // R7: dedicated lines track bank 0 bits 0 and 1 one clock later
  a_r7_dedicated_lines: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqPin0 == $past(statusFlat[0]) && irqPin1 == $past(statusFlat[1])));

  // R8: shared line is the OR of the remaining bits one clock later
  a_r8_shared_line: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqShared == ($past(statusFlat[TOT-1:2]) != '0)));

  // R10: no wake pulse unless halted in the preceding cycle
  a_r10_wake_needs_halt: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(halted));

endmodule

bind gpio_edge_irq_unit gpio_edge_checker #(.TOT(TOT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pinDir     (pinDir),
  .halted     (halted),
  .statusFlat (statusFlat),
  .clrFlat    (clrFlat),
  .irqPin0    (irqPin0),
  .irqPin1    (irqPin1),
  .irqShared  (irqShared),
  .wakeReq    (wakeReq)
);

// File: tb/tb_gpio_edge_irq_unit.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq_unit;

  localparam int TOT = 128;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [TOT-1:0] pinIn = '1;
  logic [TOT-1:0] pinDir = '0;
  logic           halted = 1'b1;
  logic [11:0]    regAddr = '0;
  logic           regWrEn = 1'b0;
  logic [31:0]    regWrData = '0;
  logic [31:0]    regRdData;
  logic           irqPin0, irqPin1, irqShared, wakeReq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gpio_edge_irq_unit dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinDir(pinDir), .halted(halted),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqPin0(irqPin0), .irqPin1(irqPin1),
    .irqShared(irqShared), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic stepClk();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    stepClk();
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic readCheck(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    // pins high and halted through reset; first cycle must stay quiet (R12)
    stepClk();
    rstN = 1'b1;
    stepClk();
    check("R12 no wake after reset", {31'd0, wakeReq}, 32'd0);
    stepClk();
    check("R12 no wake later", {31'd0, wakeReq}, 32'd0);
    readCheck("R1 reset rise en", 12'h030, 32'd0);
    readCheck("R1 reset fall en", 12'h13C, 32'd0);
    readCheck("R12 reset status", 12'h048, 32'd0);
    check("R7 irq0 reset", {31'd0, irqPin0}, 32'd0);
    check("R8 shared reset", {31'd0, irqShared}, 32'd0);
    halted = 1'b0;
    pinIn = '0;
    stepClk();
    stepClk();
  endtask

  task automatic testEnableRegs();
    logic [11:0] rAddr[4] = '{12'h030, 12'h034, 12'h038, 12'h130};
    logic [11:0] fAddr[4] = '{12'h03C, 12'h040, 12'h044, 12'h13C};
    for (int b = 0; b < 4; b++) begin
      regWrite(rAddr[b], 32'hA500_0000 + b);
      regWrite(fAddr[b], 32'h5A00_0010 + b);
    end
    for (int b = 0; b < 4; b++) begin
      readCheck("R1 rise readback", rAddr[b], 32'hA500_0000 + b);
      readCheck("R1 fall readback", fAddr[b], 32'h5A00_0010 + b);
    end
    for (int b = 0; b < 4; b++) begin
      regWrite(rAddr[b], 32'd0);
      regWrite(fAddr[b], 32'd0);
    end
  endtask

  task automatic testRising();
    regWrite(12'h030, 32'h0000_0022);
    regWrite(12'h03C, 32'h0000_0001);
    pinIn[5] = 1'b1;
    stepClk();
    readCheck("R2 rising sets bit5", 12'h048, 32'h20);
    stepClk();
    check("R8 shared on bit5", {31'd0, irqShared}, 32'd1);
    check("R7 irq0 idle", {31'd0, irqPin0}, 32'd0);
    pinIn[5] = 1'b0;
    stepClk();
    readCheck("R3 fall not enabled", 12'h048, 32'h20);
    regWrite(12'h048, 32'h20);
    readCheck("R5 cleared", 12'h048, 32'h0);
    stepClk();
    check("R8 shared drops", {31'd0, irqShared}, 32'd0);
  endtask

  task automatic testFallingAndDedicated();
    pinIn[0] = 1'b1;
    stepClk();
    readCheck("R2 rise not enabled on pin0", 12'h048, 32'h0);
    pinIn[0] = 1'b0;
    stepClk();
    readCheck("R3 falling sets bit0", 12'h048, 32'h1);
    stepClk();
    check("R7 irq0 set", {31'd0, irqPin0}, 32'd1);
    check("R7 irq1 clear", {31'd0, irqPin1}, 32'd0);
    check("R8 shared idle", {31'd0, irqShared}, 32'd0);
    pinIn[1] = 1'b1;
    stepClk();
    readCheck("R2 rising sets bit1", 12'h048, 32'h3);
    regWrite(12'h048, 32'h1);
    readCheck("R5 partial clear", 12'h048, 32'h2);
    stepClk();
    check("R7 irq0 dropped", {31'd0, irqPin0}, 32'd0);
    check("R7 irq1 set", {31'd0, irqPin1}, 32'd1);
    regWrite(12'h048, 32'h2);
    stepClk();
    check("R7 irq1 dropped", {31'd0, irqPin1}, 32'd0);
  endtask

  task automatic testOutputPin();
    pinDir[5] = 1'b1;
    pinIn[5] = 1'b1;
    stepClk();
    readCheck("R4 output pin ignored", 12'h048, 32'h0);
    stepClk();
    check("R4 shared stays low", {31'd0, irqShared}, 32'd0);
    pinDir[5] = 1'b0;
    stepClk();
  endtask

  task automatic testCollision();
    regWrite(12'h034, 32'h4);
    regWrite(12'h040, 32'h4);
    pinIn[34] = 1'b1;
    stepClk();
    readCheck("R2 bank1 bit2 set", 12'h04C, 32'h4);
    // falling edge and clear hit the same bit in one cycle
    pinIn[34] = 1'b0;
    regWrite(12'h04C, 32'h4);
    readCheck("R6 edge beats clear", 12'h04C, 32'h4);
    regWrite(12'h04C, 32'h4);
    readCheck("R5 clear alone", 12'h04C, 32'h0);
  endtask

  task automatic testWake();
    halted = 1'b1;
    pinIn[3] = 1'b1;
    stepClk();
    check("R9 wake on masked pin", {31'd0, wakeReq}, 32'd1);
    readCheck("R9 no status without enable", 12'h048, 32'h0);
    stepClk();
    check("R9 pulse one cycle", {31'd0, wakeReq}, 32'd0);
    pinIn[2] = 1'b1;
    stepClk();
    check("R10 pin outside mask", {31'd0, wakeReq}, 32'd0);
    pinDir[3] = 1'b1;
    pinIn[3] = 1'b0;
    stepClk();
    check("R10 output pin no wake", {31'd0, wakeReq}, 32'd0);
    pinDir[3] = 1'b0;
    halted = 1'b0;
    pinIn[3] = 1'b1;
    stepClk();
    check("R10 not halted", {31'd0, wakeReq}, 32'd0);
    halted = 1'b1;
    pinIn[96] = 1'b1;
    stepClk();
    check("R9 bank3 wake", {31'd0, wakeReq}, 32'd1);
    halted = 1'b0;
    stepClk();
  endtask

  task automatic testUnmapped();
    regWrite(12'h030, 32'h20);
    pinIn[5] = 1'b0;
    stepClk();
    pinIn[5] = 1'b1;
    stepClk();
    readCheck("R2 setup bit5", 12'h048, 32'h20);
    regWrite(12'h02C, 32'hFFFF_FFFF);
    regWrite(12'h000, 32'hFFFF_FFFF);
    regWrite(12'h148 + 12'h4, 32'hFFFF_FFFF);
    readCheck("R11 status untouched", 12'h048, 32'h20);
    readCheck("R11 rise untouched", 12'h030, 32'h20);
    readCheck("R11 read zero 0x02C", 12'h02C, 32'h0);
    readCheck("R11 read zero 0x000", 12'h000, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testEnableRegs();
    testRising();
    testFallingAndDedicated();
    testOutputPin();
    testCollision();
    testWake();
    testUnmapped();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule